// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

The controller collects a parameterised number of interrupt source nodes and drives a single active-low interrupt request line to a processor. Every node holds an enable bit, a programmable priority level and a pending flag. Software programs the nodes through a small register bus. A peripheral can also set a node's pending flag with a one-cycle pulse. The controller picks the best qualified pending node. It requests service only when that node's priority is strictly higher than the priority level now in service.

Service begins and ends through two fixed bus addresses. A full-word read of the vector base returns the winning node's vector and raises the current level to that node's priority. The same read stores the old level on a stack and clears the node's pending flag. A full-word write to the base plus 0x100 pops the stack and returns to the earlier level. When nothing qualifies, the read returns the base address itself as a default vector and has no effect. A control bit switches off all of these side effects, so that a debugger can inspect the vector addresses safely.

Top module: `nic_core`

## Requirements
- R1: After reset every node has enable 0, priority 0 and pending 0. The current level is 0, the control register (address 0x080, bit 0 = side-effect enable) reads 1, and irq_n is high.
- R2: Node i's register sits at byte address 4*i: bit 0 is enable, bit 1 is pending and bits [10:8] are priority. A node qualifies only when it is enabled, its priority is nonzero and it is pending.
- R3: A src_set pulse sets the node's pending flag even when the node is disabled. A register write loads pending from bit 1. When a src_set pulse and a clearing write reach the same node in one cycle, the pulse wins.
- R4: Among the qualified nodes the highest priority wins, and equal priorities go to the lowest index. irq_n is low exactly when the winner's priority is above the current level.
- R5: A word read (bus_size 2) of 0x800 while irq_n is low returns 0x800 + 4*index + 4. In the next cycle the current level equals the winner's priority and the winner's pending flag is clear.
- R6: A read of 0x800 while irq_n is high returns 0x800 and changes neither the current level nor any pending flag.
- R7: A word write to 0x900 restores the level that was in force before the most recent acknowledge. When no acknowledge is outstanding, the write is ignored.
- R8: Byte (bus_size 0) and halfword (bus_size 1) accesses to 0x800 or 0x900 return the same data as a word access but have no side effects.
- R9: When control bit 0 is 0, accesses to 0x800 and 0x900 have no side effects.
- R10: A qualified node whose priority is less than or equal to the current level waits until enough exits bring the level below its priority. A priority-1 node can therefore act as a deferred interrupt.
- R11: Disabling the only requesting node, clearing its pending flag or lowering its priority raises irq_n. A following vector read then returns the default vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| src_set | input | NUM_NODES | Peripheral pulses that set pending flags |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check four things on every cycle. An acknowledge lifts the current level to the winner's priority. An exit always lowers the level, and an exit with no outstanding acknowledge leaves it unchanged. Narrow accesses, default reads and accesses with the side effects disabled never move the level. They also check that a src_set pulse always lands in its pending flag and that a request is never raised without an enabled pending node. Only the bench scenarios can show the other behaviours: the exact vector values and the lowest-index tie-break, the deferred priority-1 service across nested exits, and the loss of a request when software withdraws its only source.

// File: rtl/nic_pkg.sv
package nic_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    localparam int unsigned PRIO_LSB = 8;  // priority field position in a node register
endpackage

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
    parameter int unsigned NUM_NODES = 8,
    parameter int unsigned PRIO_W    = 3,
    localparam int unsigned IDX_W    = $clog2(NUM_NODES)
) (
    input  logic [NUM_NODES-1:0]             en,
    input  logic [NUM_NODES-1:0]             pend,
    input  logic [NUM_NODES-1:0][PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]                win_prio,
    output logic [IDX_W-1:0]                 win_idx
);
    // Strict greater-than while scanning upward keeps the lowest index on ties.
    always_comb begin
        win_prio = '0;
        win_idx  = '0;
        for (int i = 0; i < NUM_NODES; i++) begin
            if (en[i] && pend[i] && (prio[i] > win_prio)) begin
                win_prio = prio[i];
                win_idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nic_prio_stack.sv
module nic_prio_stack #(
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_val,
    output logic [PRIO_W-1:0] top_val,
    output logic              empty
);
    typedef struct packed {
        logic [DEPTH-1:0][PRIO_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push && (st_q.cnt < CNT_W'(DEPTH))) begin
            st_d.mem[PTR_W'(st_q.cnt)] = push_val;
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign empty   = (st_q.cnt == '0);
    assign top_val = empty ? '0 : st_q.mem[PTR_W'(st_q.cnt - 1'b1)];
endmodule

// File: rtl/nic_core.sv
module nic_core #(
    parameter int unsigned          NUM_NODES = 8,
    parameter int unsigned          PRIO_W    = 3,
    parameter int unsigned          ADDR_W    = 12,
    parameter logic [ADDR_W-1:0]    VEC_BASE  = 12'h800,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = 12'h080
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_NODES-1:0] src_set,
    output logic                 irq_n
);
    import nic_pkg::*;

    localparam int unsigned IDX_W  = $clog2(NUM_NODES);
    localparam int unsigned LEVELS = 1 << PRIO_W;
    localparam logic [ADDR_W-1:0] EXIT_ADDR = VEC_BASE + ADDR_W'(12'h100);

    typedef struct packed {
        logic [NUM_NODES-1:0]             en;
        logic [NUM_NODES-1:0]             pend;
        logic [NUM_NODES-1:0][PRIO_W-1:0] prio;
        logic [PRIO_W-1:0]                cur;
        logic                             te;
    } state_t;

    state_t st_d, st_q;

    logic [PRIO_W-1:0] win_prio;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] stk_top;
    logic              stk_empty;
    logic              req_active, do_ack, do_exit;
    logic              node_hit, ctrl_hit, vec_hit, exit_hit, fx_ok;
    logic [IDX_W-1:0]  node_idx;
    logic [31:0]       vec_val;
    logic              unused_wdata;

    nic_prio_enc #(.NUM_NODES(NUM_NODES), .PRIO_W(PRIO_W)) u_enc (
        .en       (st_q.en),
        .pend     (st_q.pend),
        .prio     (st_q.prio),
        .win_prio (win_prio),
        .win_idx  (win_idx)
    );

    nic_prio_stack #(.PRIO_W(PRIO_W), .DEPTH(LEVELS)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (do_ack),
        .pop      (do_exit),
        .push_val (st_q.cur),
        .top_val  (stk_top),
        .empty    (stk_empty)
    );

    assign node_hit   = bus_valid && ((bus_addr >> 2) < ADDR_W'(NUM_NODES));
    assign node_idx   = bus_addr[IDX_W+1:2];
    assign ctrl_hit   = bus_valid && (bus_addr == CTRL_ADDR);
    assign vec_hit    = bus_valid && !bus_write && (bus_addr == VEC_BASE);
    assign exit_hit   = bus_valid && bus_write && (bus_addr == EXIT_ADDR);
    assign fx_ok      = st_q.te && (acc_size_e'(bus_size) == SZ_WORD);
    assign req_active = (win_prio > st_q.cur);
    assign do_ack     = vec_hit && fx_ok && req_active;
    assign do_exit    = exit_hit && fx_ok && !stk_empty;
    assign vec_val    = 32'(VEC_BASE) + ({{(32-IDX_W){1'b0}}, win_idx} << 2) + 32'd4;
    assign unused_wdata = ^{bus_wdata[31:PRIO_LSB+PRIO_W], bus_wdata[PRIO_LSB-1:2]};

    always_comb begin
        st_d = st_q;
        if (bus_write && node_hit) begin
            st_d.en[node_idx]   = bus_wdata[0];
            st_d.pend[node_idx] = bus_wdata[1];
            st_d.prio[node_idx] = bus_wdata[PRIO_LSB +: PRIO_W];
        end
        if (bus_write && ctrl_hit) st_d.te = bus_wdata[0];
        if (do_ack) begin
            st_d.pend[win_idx] = 1'b0;
            st_d.cur           = win_prio;
        end
        if (do_exit) st_d.cur = stk_top;
        st_d.pend = st_d.pend | src_set;  // peripheral set wins over any clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.te <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            if (node_hit) begin
                bus_rdata[0] = st_q.en[node_idx];
                bus_rdata[1] = st_q.pend[node_idx];
                bus_rdata[PRIO_LSB +: PRIO_W] = st_q.prio[node_idx];
            end else if (ctrl_hit) begin
                bus_rdata[0] = st_q.te;
            end else if (vec_hit) begin
                bus_rdata = req_active ? vec_val : 32'(VEC_BASE);
            end
        end
    end

    assign irq_n = !req_active;

    // Observation points for the bound checker
    logic [PRIO_W-1:0]    cur_prio;
    logic [NUM_NODES-1:0] en_vec, pend_vec;
    logic                 te_bit;
    assign cur_prio = st_q.cur;
    assign en_vec   = st_q.en;
    assign pend_vec = st_q.pend;
    assign te_bit   = st_q.te;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int unsigned       NUM_NODES = 8,
    parameter int unsigned       PRIO_W    = 3,
    parameter int unsigned       ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] VEC_BASE  = 12'h800
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [1:0]           bus_size,
    input logic [NUM_NODES-1:0] src_set,
    input logic                 irq_n,
    input logic [PRIO_W-1:0]    cur_prio,
    input logic [PRIO_W-1:0]    win_prio,
    input logic [NUM_NODES-1:0] en_vec,
    input logic [NUM_NODES-1:0] pend_vec,
    input logic                 stk_empty,
    input logic                 te_bit
);
    localparam logic [ADDR_W-1:0] EXIT_ADDR = VEC_BASE + ADDR_W'(12'h100);

    logic vec_rd, exit_wr, is_word, special;
    assign vec_rd  = bus_valid && !bus_write && (bus_addr == VEC_BASE);
    assign exit_wr = bus_valid && bus_write && (bus_addr == EXIT_ADDR);
    assign is_word = (bus_size == 2'd2);
    assign special = bus_valid && ((bus_addr == VEC_BASE) || (bus_addr == EXIT_ADDR));

    p_req_needs_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((en_vec & pend_vec) != '0));

    p_src_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend_vec & $past(src_set)) == $past(src_set)));

    p_ack_raises_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && is_word && te_bit && !irq_n) |=> (cur_prio == $past(win_prio)));

    p_default_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && irq_n) |=> $stable(cur_prio));

    p_exit_lowers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_wr && is_word && te_bit && !stk_empty) |=> (cur_prio < $past(cur_prio)));

    p_exit_empty_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_wr && stk_empty) |=> $stable(cur_prio));

    p_narrow_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (special && !is_word) |=> $stable(cur_prio));

    p_te_off_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (special && !te_bit) |=> $stable(cur_prio));
endmodule

bind nic_core nic_checker #(
    .NUM_NODES (NUM_NODES),
    .PRIO_W    (PRIO_W),
    .ADDR_W    (ADDR_W),
    .VEC_BASE  (VEC_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .src_set   (src_set),
    .irq_n     (irq_n),
    .cur_prio  (cur_prio),
    .win_prio  (win_prio),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec),
    .stk_empty (stk_empty),
    .te_bit    (te_bit)
);

// File: tb/nic_core_tb.sv
module nic_core_tb;
    localparam int N = 8;
    localparam logic [11:0] BASE  = 12'h800;
    localparam logic [11:0] EXITA = 12'h900;
    localparam logic [11:0] CTRLA = 12'h080;
    localparam logic [1:0]  W = 2'd2, H = 2'd1, B = 2'd0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [N-1:0] src_set = '0;
    logic        irq_n;

    always #10 clk = ~clk;

    nic_core u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_set(src_set), .irq_n(irq_n)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // reference model
    bit m_en[N];
    bit m_pend[N];
    int m_prio[N];
    int m_cur = 0;
    int m_stk[$];
    bit m_te = 1;

    function automatic int m_win_idx();
        int best = 0, idx = -1;
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pend[i] && m_prio[i] > best) begin
                best = m_prio[i];
                idx = i;
            end
        return idx;
    endfunction

    function automatic bit m_irq();
        int idx = m_win_idx();
        return (idx >= 0) && (m_prio[idx] > m_cur);
    endfunction

    function automatic void m_apply_src(logic [N-1:0] src);
        for (int i = 0; i < N; i++) if (src[i]) m_pend[i] = 1'b1;
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a, logic [1:0] sz, logic [N-1:0] src);
        logic [31:0] r = '0;
        if ((a >> 2) < N) begin
            r[0] = m_en[a[4:2]];
            r[1] = m_pend[a[4:2]];
            r[10:8] = m_prio[a[4:2]][2:0];
        end else if (a == CTRLA) begin
            r[0] = m_te;
        end else if (a == BASE) begin
            if (m_irq()) begin
                int idx = m_win_idx();
                r = 32'(BASE) + 32'(4 * idx + 4);
                if (sz == W && m_te) begin
                    m_stk.push_back(m_cur);
                    m_cur = m_prio[idx];
                    m_pend[idx] = 1'b0;
                end
            end else begin
                r = 32'(BASE);
            end
        end
        m_apply_src(src);
        return r;
    endfunction

    function automatic void m_write(logic [11:0] a, logic [1:0] sz, logic [31:0] d, logic [N-1:0] src);
        if ((a >> 2) < N) begin
            m_en[a[4:2]] = d[0];
            m_pend[a[4:2]] = d[1];
            m_prio[a[4:2]] = int'(d[10:8]);
        end else if (a == CTRLA) begin
            m_te = d[0];
        end else if (a == EXITA) begin
            if (sz == W && m_te && m_stk.size() > 0) m_cur = m_stk.pop_back();
        end
        m_apply_src(src);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_op(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic [N-1:0] src, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz;
        bus_wdata = d; src_set = src;
        #1 rd = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; src_set = '0;
    endtask

    task automatic chk_irq(input string req);
        chk(req, {31'b0, irq_n}, {31'b0, !m_irq()});
    endtask

    task automatic do_wr(input string req, input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] d, input logic [N-1:0] src);
        logic [31:0] rd;
        m_write(a, sz, d, src);
        bus_op(1'b1, a, sz, d, src, rd);
        chk_irq(req);
    endtask

    task automatic do_rd(input string req, input logic [11:0] a, input logic [1:0] sz,
                         input logic [N-1:0] src, output logic [31:0] rd);
        logic [31:0] exp;
        exp = m_read(a, sz, src);
        bus_op(1'b0, a, sz, 32'h0, src, rd);
        chk(req, rd, exp);
        chk_irq(req);
    endtask

    function automatic logic [31:0] node_word(bit en, bit pend, int prio);
        return {21'b0, 3'(prio), 6'b0, pend, en};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pend[i] = 0; m_prio[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_n", {31'b0, irq_n}, 32'd1);
        do_rd("R1 ctrl", CTRLA, W, '0, rd);
        chk("R1 ctrl literal", rd, 32'd1);
        do_rd("R1 node3", 12'h00C, W, '0, rd);
        do_rd("R6 default at reset", BASE, W, '0, rd);
        chk("R6 literal", rd, 32'h800);

        // R3: pulse sets pending on a disabled node, no request (R2)
        do_wr("R3 src on disabled", 12'h0F0, W, 0, 8'h04);
        do_rd("R3 poll pending", 12'h008, W, '0, rd);
        chk("R3 pending bit", rd, 32'h2);
        do_wr("R2 enabled prio0", 12'h008, W, node_word(1, 1, 0), '0);
        do_wr("R4 prio3 raises", 12'h008, W, node_word(1, 1, 3), '0);
        chk("R4 irq low", {31'b0, irq_n}, 32'd0);

        // R4 tie, R5 ack, R10 hold equal
        do_wr("R4 node5 prio3", 12'h014, W, node_word(1, 1, 3), '0);
        do_rd("R5 ack tie", BASE, W, '0, rd);
        chk("R5 vector node2", rd, 32'h80C);
        chk("R10 equal held", {31'b0, irq_n}, 32'd1);
        do_rd("R5 pending cleared", 12'h008, W, '0, rd);

        // R8 narrow accesses
        do_rd("R8 half vec read", BASE, H, '0, rd);
        do_wr("R8 byte exit", EXITA, B, 0, '0);
        chk("R8 still serving", {31'b0, irq_n}, 32'd1);

        // R7 exit and ack of node5, empty exit
        do_wr("R7 exit", EXITA, W, 0, '0);
        chk("R7 request back", {31'b0, irq_n}, 32'd0);
        do_rd("R5 ack node5", BASE, W, '0, rd);
        chk("R5 vector node5", rd, 32'h818);
        do_wr("R7 exit2", EXITA, W, 0, '0);
        do_wr("R7 empty exit", EXITA, W, 0, '0);

        // R10 deferred prio-1 under nested service
        do_wr("R10 node1 prio5", 12'h004, W, node_word(1, 1, 5), '0);
        do_wr("R10 node6 prio1", 12'h018, W, node_word(1, 0, 1), '0);
        do_rd("R10 ack node1", BASE, W, '0, rd);
        do_wr("R10 set deferred", 12'h018, W, node_word(1, 1, 1), '0);
        chk("R10 deferred held", {31'b0, irq_n}, 32'd1);
        do_wr("R10 exit", EXITA, W, 0, '0);
        chk("R10 deferred runs", {31'b0, irq_n}, 32'd0);
        do_rd("R10 ack deferred", BASE, W, '0, rd);
        chk("R10 vector node6", rd, 32'h81C);
        do_wr("R7 exit deferred", EXITA, W, 0, '0);

        // R9 side effects disabled
        do_wr("R9 node7 prio7", 12'h01C, W, node_word(1, 1, 7), '0);
        do_wr("R9 te off", CTRLA, W, 0, '0);
        do_rd("R9 read no ack", BASE, W, '0, rd);
        chk("R9 still requesting", {31'b0, irq_n}, 32'd0);
        do_rd("R9 pending kept", 12'h01C, W, '0, rd);
        do_wr("R9 te on", CTRLA, W, 1, '0);

        // R11 withdraw only source
        do_wr("R11 disable node7", 12'h01C, W, node_word(0, 1, 7), '0);
        chk("R11 irq high", {31'b0, irq_n}, 32'd1);
        do_rd("R11 default", BASE, W, '0, rd);
        chk("R11 default literal", rd, 32'h800);

        // R3 set wins over clear in the same cycle
        do_wr("R3 set beats clear", 12'h00C, W, node_word(0, 0, 2), 8'h08);
        do_rd("R3 readback", 12'h00C, W, '0, rd);

        // constrained random mix (R2..R9)
        for (int it = 0; it < 600; it++) begin
            int op = $urandom_range(0, 9);
            logic [N-1:0] src = ($urandom_range(0, 4) == 0) ? N'($urandom) : '0;
            logic [11:0] na = 12'(4 * $urandom_range(0, N - 1));
            case (op)
                0, 1, 2: do_wr("R2 rand node write", na, W,
                               node_word(1'($urandom), 1'($urandom), $urandom_range(0, 7)), src);
                3: do_wr("R3 rand src", 12'h0F0, W, 0, N'($urandom));
                4, 5: do_rd("R5 rand vec read", BASE, W, src, rd);
                6: do_wr("R7 rand exit", EXITA, W, 0, src);
                7: begin
                    if ($urandom_range(0, 1) == 0) do_rd("R8 rand narrow read", BASE, 2'($urandom_range(0, 1)), src, rd);
                    else do_wr("R8 rand narrow exit", EXITA, 2'($urandom_range(0, 1)), 0, src);
                end
                8: do_rd("R3 rand node read", na, W, src, rd);
                default: do_wr("R9 rand te", CTRLA, W, 32'($urandom_range(0, 3) != 0), '0);
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule